// File: doc/BRIEF.md
# Battery-Event Power Mode Controller

This block turns slow, asynchronous system events into requests that the rest of the chip acts on. Its inputs are four active-low battery warnings, an AC-present level, an external interrupt request line and an active-low ring line from a modem. Its outputs are a prioritised power-mode request (low-speed clock, sleep or suspend), a management interrupt request, a modem interrupt, a one-cycle resume pulse and an active-low latched power-control level.

Each battery warning acts on its own falling edge. Each one has a fixed set of allowed actions, chosen through a small control register. All pending events are kept in a sticky status register, and software clears each bit by writing a one to it. When the override is enabled and AC power is present, battery events have no effect. Software programs the block through a simple synchronous write port and reads it back through a combinational read port.

Top module: `batt_pm_ctrl`

## Requirements
- R1: After reset, registers at addresses 0, 1 and 2 read 0, `mode_req` is 0, and `smi_req`, `modem_irq` and `resume_req` are low. `lph_n` is high. Address 3 reads 0x4F while the inputs are idle (battery lines high, ring high, external line low, AC low).
- R2: Every asynchronous input passes through two flops, and edges are detected on the synchronised level. A battery-line change driven just after clock edge 0 sets its status bit on edge 3 and not before.
- R3: Control bit 0 enables battery line 1 (`bat_low_n[0]`). On a falling edge, control bit 1 selects between setting status bit 0 (interrupt, bit1=1) and status bit 5 (low-speed request, bit1=0). A rising edge does nothing.
- R4: Control bit 2 enables line 2. Control bit 3 selects between status bit 1 (interrupt) and status bit 6 (sleep request). The sleep bit is set only while `in_sleep` is low.
- R5: Control bit 4 enables line 3. Its falling edge can only set status bit 2 (interrupt).
- R6: Control bit 5 enables line 4. Its falling edge sets status bit 7 (suspend request).
- R7: While control bit 6 is set and AC is present, battery edges set no status bit. External and ring events are unaffected.
- R8: `lph_n` equals the inverse of synchronised line 4 while AC is absent and control bit 5 is set. Otherwise it is high.
- R9: With bit 0 of address 1 set, an edge on `ext_smi` sets status bit 3. Bit 1 of address 1 picks the edge: 1 for rising, 0 for falling.
- R10: Any change on `ring_n` sets status bit 4, which drives `modem_irq`. When control bit 7 is set, the change also gives exactly one cycle of `resume_req`.
- R11: Writing address 2 clears the status bits written as one and leaves the others. A bit that is set and cleared in the same cycle stays set. `smi_req` is the OR of status bits 0 to 3 and holds until they are cleared.
- R12: `mode_req` is 3 when status bit 7 is set. Otherwise it is 2 when bit 6 is set, otherwise 1 when bit 5 is set, otherwise 0.
- R13: Address 0 reads back the control byte. Address 1 reads its two bits with zeros above them. Address 3 reads the synchronised levels: bits 3..0 battery lines, bit 4 AC, bit 5 external line, bit 6 ring, bit 7 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_low_n | input | 4 | Battery warning lines, active low, asynchronous |
| ac_present | input | 1 | AC power present, asynchronous |
| ext_smi | input | 1 | External interrupt request, asynchronous |
| ring_n | input | 1 | Modem ring line, asynchronous |
| in_sleep | input | 1 | High while the system is already in sleep |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| mode_req | output | 2 | Power mode request: 0 none, 1 low speed, 2 sleep, 3 suspend |
| smi_req | output | 1 | Management interrupt request |
| modem_irq | output | 1 | Modem status interrupt |
| resume_req | output | 1 | One-cycle resume pulse |
| lph_n | output | 1 | Latched power control, active low |

## Verification
The hardest case to reach from the ports is a status bit that is set and cleared by software in the same cycle. The bench drives a battery line low, counts exactly two clock edges, and then places the clearing write in the cycle where the synchronised edge is seen, so that both act on the same edge. Suppression and sleep gating depend on levels that must already be synchronised when the edge arrives. Each table vector therefore applies AC and `in_sleep` several cycles before it pulls the battery lines.

// File: rtl/batt_pm_pkg.sv
package batt_pm_pkg;
  localparam int unsigned NUM_BL   = 4;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CFG_W    = 2;
  localparam int unsigned NUM_IN   = NUM_BL + 3;
  localparam int unsigned IDX_AC   = NUM_BL;
  localparam int unsigned IDX_EXT  = NUM_BL + 1;
  localparam int unsigned IDX_RING = NUM_BL + 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_LEVEL = 2'd3;

  // control byte
  localparam int unsigned C_B1_EN    = 0;
  localparam int unsigned C_B1_SMI   = 1;
  localparam int unsigned C_B2_EN    = 2;
  localparam int unsigned C_B2_SMI   = 3;
  localparam int unsigned C_B3_EN    = 4;
  localparam int unsigned C_B4_EN    = 5;
  localparam int unsigned C_AC_OVR   = 6;
  localparam int unsigned C_RING_RES = 7;

  // external request config
  localparam int unsigned G_EXT_EN  = 0;
  localparam int unsigned G_EXT_POL = 1;

  // status byte
  localparam int unsigned S_B1_SMI  = 0;
  localparam int unsigned S_B2_SMI  = 1;
  localparam int unsigned S_B3_SMI  = 2;
  localparam int unsigned S_EXT_SMI = 3;
  localparam int unsigned S_RING    = 4;
  localparam int unsigned S_LOWSPD  = 5;
  localparam int unsigned S_SLEEP   = 6;
  localparam int unsigned S_SUSP    = 7;
  localparam logic [REG_W-1:0] BATT_MASK = 8'hE7;

  // idle levels: ring high, ext low, ac low, battery lines high
  localparam logic [NUM_IN-1:0] IN_IDLE = 7'b100_1111;

  typedef enum logic [1:0] {
    MODE_NONE    = 2'd0,
    MODE_LOWSPD  = 2'd1,
    MODE_SLEEP   = 2'd2,
    MODE_SUSPEND = 2'd3
  } pm_mode_e;

  function automatic pm_mode_e pick_mode(input logic lo, input logic sl, input logic su);
    if (su)      return MODE_SUSPEND;
    else if (sl) return MODE_SLEEP;
    else if (lo) return MODE_LOWSPD;
    else         return MODE_NONE;
  endfunction

  function automatic logic edge_hit(input logic rising, input logic prv, input logic cur);
    return rising ? (~prv & cur) : (prv & ~cur);
  endfunction
endpackage

// File: rtl/bpm_sync.sv
module bpm_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[i];
          sync_q <= RST_VAL[i];
        end else begin
          meta_q <= async_in[i];
          sync_q <= meta_q;
        end
      end
      assign lvl[i] = sync_q;
    end
  endgenerate

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2: synchronised level lags the pin by two edges
  a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (lvl == $past(async_in, 2)));
endmodule

// File: rtl/bpm_event_map.sv
module bpm_event_map
  import batt_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ctrl,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [NUM_IN-1:0] lvl,
  input  logic              in_sleep,
  output logic [REG_W-1:0]  set_vec,
  output logic              ring_chg,
  output logic              lph_n
);
  logic [NUM_BL-1:0] bl_prv_q;
  logic              ext_prv_q, ring_prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_prv_q   <= IN_IDLE[NUM_BL-1:0];
      ext_prv_q  <= IN_IDLE[IDX_EXT];
      ring_prv_q <= IN_IDLE[IDX_RING];
    end else begin
      bl_prv_q   <= lvl[NUM_BL-1:0];
      ext_prv_q  <= lvl[IDX_EXT];
      ring_prv_q <= lvl[IDX_RING];
    end
  end

  logic              suppress;
  logic [NUM_BL-1:0] bl_fall, bl_hit;

  assign suppress = ctrl[C_AC_OVR] & lvl[IDX_AC];
  generate
    for (genvar i = 0; i < NUM_BL; i++) begin : g_fall
      assign bl_fall[i] = edge_hit(1'b0, bl_prv_q[i], lvl[i]);
    end
  endgenerate
  assign bl_hit   = bl_fall & {NUM_BL{~suppress}};
  assign ring_chg = ring_prv_q ^ lvl[IDX_RING];

  always_comb begin
    set_vec            = '0;
    set_vec[S_B1_SMI]  = bl_hit[0] & ctrl[C_B1_EN] &  ctrl[C_B1_SMI];
    set_vec[S_LOWSPD]  = bl_hit[0] & ctrl[C_B1_EN] & ~ctrl[C_B1_SMI];
    set_vec[S_B2_SMI]  = bl_hit[1] & ctrl[C_B2_EN] &  ctrl[C_B2_SMI];
    set_vec[S_SLEEP]   = bl_hit[1] & ctrl[C_B2_EN] & ~ctrl[C_B2_SMI] & ~in_sleep;
    set_vec[S_B3_SMI]  = bl_hit[2] & ctrl[C_B3_EN];
    set_vec[S_SUSP]    = bl_hit[3] & ctrl[C_B4_EN];
    set_vec[S_EXT_SMI] = cfg[G_EXT_EN] &
                         edge_hit(cfg[G_EXT_POL], ext_prv_q, lvl[IDX_EXT]);
    set_vec[S_RING]    = ring_chg;
  end

  assign lph_n = (ctrl[C_B4_EN] & ~lvl[IDX_AC]) ? ~lvl[NUM_BL-1] : 1'b1;
endmodule

// File: rtl/bpm_regs.sv
module bpm_regs
  import batt_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  set_vec,
  input  logic [NUM_IN-1:0] lvl,
  output logic [REG_W-1:0]  ctrl,
  output logic [CFG_W-1:0]  cfg,
  output logic [REG_W-1:0]  stat,
  output logic [REG_W-1:0]  rd_data
);
  logic             wr_stat;
  logic [REG_W-1:0] clr_mask;

  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign clr_mask = wr_stat ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      cfg  <= '0;
      stat <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl <= wr_data;
      if (wr_en && wr_addr == A_CFG)  cfg  <= wr_data[CFG_W-1:0];
      stat <= (stat & ~clr_mask) | set_vec;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl;
      A_CFG:   rd_data = {{(REG_W-CFG_W){1'b0}}, cfg};
      A_STAT:  rd_data = stat;
      default: rd_data = {{(REG_W-NUM_IN){1'b0}}, lvl};
    endcase
  end

  // R11: without a status write no pending bit is lost
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/bpm_mode_arb.sv
module bpm_mode_arb
  import batt_pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend_lo,
  input  logic     pend_sl,
  input  logic     pend_su,
  output pm_mode_e mode
);
  assign mode = pick_mode(pend_lo, pend_sl, pend_su);

  // R12: ordering of the three requests
  a_r12_suspend_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_su |-> (mode == MODE_SUSPEND));
  a_r12_sleep_over_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_sl && !pend_su) |-> (mode == MODE_SLEEP));
endmodule

// File: rtl/batt_pm_ctrl.sv
module batt_pm_ctrl
  import batt_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BL-1:0] bat_low_n,
  input  logic              ac_present,
  input  logic              ext_smi,
  input  logic              ring_n,
  input  logic              in_sleep,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [1:0]        mode_req,
  output logic              smi_req,
  output logic              modem_irq,
  output logic              resume_req,
  output logic              lph_n
);
  logic [NUM_IN-1:0] lvl;
  logic [REG_W-1:0]  ctrl, stat, set_vec;
  logic [CFG_W-1:0]  cfg;
  logic              ring_chg;
  logic              resume_q;
  pm_mode_e          mode;

  bpm_sync #(.W(NUM_IN), .RST_VAL(IN_IDLE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ring_n, ext_smi, ac_present, bat_low_n}),
    .lvl      (lvl)
  );

  bpm_event_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .cfg      (cfg),
    .lvl      (lvl),
    .in_sleep (in_sleep),
    .set_vec  (set_vec),
    .ring_chg (ring_chg),
    .lph_n    (lph_n)
  );

  bpm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .set_vec (set_vec),
    .lvl     (lvl),
    .ctrl    (ctrl),
    .cfg     (cfg),
    .stat    (stat),
    .rd_data (rd_data)
  );

  bpm_mode_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_lo (stat[S_LOWSPD]),
    .pend_sl (stat[S_SLEEP]),
    .pend_su (stat[S_SUSP]),
    .mode    (mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume_q <= 1'b0;
    else        resume_q <= ring_chg & ctrl[C_RING_RES];
  end

  assign resume_req = resume_q;
  assign mode_req   = mode;
  assign smi_req    = |stat[S_EXT_SMI:S_B1_SMI];
  assign modem_irq  = stat[S_RING];

  // R7: AC override keeps battery bits from rising
  a_r7_override_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[C_AC_OVR] && lvl[IDX_AC]) |=> ((stat & ~$past(stat) & BATT_MASK) == '0));
  // R4: sleep request never newly raised while already asleep
  a_r4_sleep_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[S_SLEEP]) |-> $past(!in_sleep));
endmodule

// File: tb/batt_pm_ctrl_tb.sv
module batt_pm_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bat_low_n = 4'hF;
  logic       ac_present = 1'b0, ext_smi = 1'b0, ring_n = 1'b1, in_sleep = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] mode_req;
  logic       smi_req, modem_irq, resume_req, lph_n;

  int n_chk = 0, n_err = 0, res_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  batt_pm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bat_low_n(bat_low_n), .ac_present(ac_present),
    .ext_smi(ext_smi), .ring_n(ring_n), .in_sleep(in_sleep),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .mode_req(mode_req), .smi_req(smi_req),
    .modem_irq(modem_irq), .resume_req(resume_req), .lph_n(lph_n)
  );

  always @(negedge clk) if (rst_n && resume_req) res_cnt <= res_cnt + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {ctrl, cfg, ac, in_sleep, bat_low_n, ext, expected status, expected mode}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {8'h01, 2'b00, 1'b0, 1'b0, 4'b1110, 1'b0, 8'h20, 2'd1},  // R3 low speed
    {8'h03, 2'b00, 1'b0, 1'b0, 4'b1110, 1'b0, 8'h01, 2'd0},  // R3 interrupt
    {8'h04, 2'b00, 1'b0, 1'b0, 4'b1101, 1'b0, 8'h40, 2'd2},  // R4 sleep
    {8'h04, 2'b00, 1'b0, 1'b1, 4'b1101, 1'b0, 8'h00, 2'd0},  // R4 already asleep
    {8'h0C, 2'b00, 1'b0, 1'b0, 4'b1101, 1'b0, 8'h02, 2'd0},  // R4 interrupt
    {8'h10, 2'b00, 1'b0, 1'b0, 4'b1011, 1'b0, 8'h04, 2'd0},  // R5
    {8'h20, 2'b00, 1'b0, 1'b0, 4'b0111, 1'b0, 8'h80, 2'd3},  // R6
    {8'h25, 2'b00, 1'b0, 1'b0, 4'b0000, 1'b0, 8'hE0, 2'd3},  // R12 all three
    {8'h05, 2'b00, 1'b0, 1'b0, 4'b1100, 1'b0, 8'h60, 2'd2},  // R12 sleep over low
    {8'h75, 2'b00, 1'b1, 1'b0, 4'b0000, 1'b0, 8'h00, 2'd0},  // R7 suppressed
    {8'h35, 2'b00, 1'b1, 1'b0, 4'b0000, 1'b0, 8'hE4, 2'd3},  // R7 AC without override
    {8'h00, 2'b00, 1'b0, 1'b0, 4'b0000, 1'b0, 8'h00, 2'd0},  // R3/R4/R5/R6 disabled
    {8'h00, 2'b01, 1'b0, 1'b0, 4'b1111, 1'b1, 8'h00, 2'd0},  // R9 rising ignored in falling mode
    {8'h00, 2'b11, 1'b0, 1'b0, 4'b1111, 1'b1, 8'h08, 2'd0},  // R9 rising
    {8'h00, 2'b10, 1'b0, 1'b0, 4'b1111, 1'b1, 8'h00, 2'd0},  // R9 disabled
    {8'h40, 2'b11, 1'b1, 1'b0, 4'b1111, 1'b1, 8'h08, 2'd0}   // R7 external unaffected
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int r0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(2'd0, r); chk("R1 ctrl", r, 8'h00);
    rd(2'd1, r); chk("R1 cfg", r, 8'h00);
    rd(2'd2, r); chk("R1 status", r, 8'h00);
    rd(2'd3, r); chk("R1 levels", r, 8'h4F);
    chk("R1 outputs", {2'b00, mode_req, smi_req, modem_irq, resume_req, lph_n}, 8'h01);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      wr(2'd0, v[26:19]);
      wr(2'd1, {6'b0, v[18:17]});
      @(negedge clk); ac_present = v[16]; in_sleep = v[15];
      idle(6);
      wr(2'd2, 8'hFF);
      @(negedge clk); bat_low_n = v[14:11]; ext_smi = v[10];
      idle(5);
      rd(2'd2, r); chk($sformatf("R3/R4/R5/R6/R7/R9 vector %0d status", i), r, v[9:2]);
      chk($sformatf("R12 vector %0d mode", i), {6'b0, mode_req}, {6'b0, v[1:0]});
      @(negedge clk); bat_low_n = 4'hF; ext_smi = 1'b0; ac_present = 1'b0; in_sleep = 1'b0;
    end
    idle(6);

    // R3 rising edge has no effect
    wr(2'd0, 8'h00);
    @(negedge clk); bat_low_n[0] = 1'b0;
    idle(5);
    wr(2'd0, 8'h01); wr(2'd2, 8'hFF);
    @(negedge clk); bat_low_n[0] = 1'b1;
    idle(5);
    rd(2'd2, r); chk("R3 rising ignored", r, 8'h00);

    // R2 exact latency
    wr(2'd0, 8'h10); wr(2'd2, 8'hFF);
    @(negedge clk); rd_addr = 2'd2; bat_low_n[2] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 not before edge 3", rd_data, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R2 set on edge 3", rd_data, 8'h04);

    // R11 hold and write-one-to-clear
    idle(20);
    chk("R11 smi held", {7'b0, smi_req}, 8'h01);
    wr(2'd2, 8'h02);
    rd(2'd2, r); chk("R11 other bit untouched", r, 8'h04);
    wr(2'd2, 8'h04);
    rd(2'd2, r); chk("R11 cleared", r, 8'h00);
    chk("R11 smi dropped", {7'b0, smi_req}, 8'h00);

    // R11 set wins over simultaneous clear
    @(negedge clk); bat_low_n[2] = 1'b1;
    idle(5);
    @(negedge clk); bat_low_n[2] = 1'b0;
    idle(5);
    @(negedge clk); bat_low_n[2] = 1'b1;
    idle(5);
    @(negedge clk); bat_low_n[2] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h04;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, r); chk("R11 set wins", r, 8'h04);
    @(negedge clk); bat_low_n[2] = 1'b1;
    idle(5);
    wr(2'd2, 8'hFF);

    // R8 latched power output
    wr(2'd0, 8'h20);
    idle(4);
    chk("R8 line high", {7'b0, lph_n}, 8'h00);
    @(negedge clk); bat_low_n[3] = 1'b0;
    idle(4);
    chk("R8 line low", {7'b0, lph_n}, 8'h01);
    @(negedge clk); bat_low_n[3] = 1'b1; ac_present = 1'b1;
    idle(4);
    chk("R8 AC present", {7'b0, lph_n}, 8'h01);
    @(negedge clk); ac_present = 1'b0;
    idle(4);
    chk("R8 AC gone", {7'b0, lph_n}, 8'h00);
    wr(2'd0, 8'h00);
    idle(1);
    chk("R8 disabled", {7'b0, lph_n}, 8'h01);
    wr(2'd2, 8'hFF);

    // R10 ring changes
    wr(2'd0, 8'h80);
    r0 = res_cnt;
    @(negedge clk); ring_n = 1'b0;
    idle(5);
    chk("R10 irq on fall", {7'b0, modem_irq}, 8'h01);
    chk("R10 one resume pulse", 8'(res_cnt - r0), 8'h01);
    wr(2'd2, 8'h10);
    chk("R10 irq cleared", {7'b0, modem_irq}, 8'h00);
    @(negedge clk); ring_n = 1'b1;
    idle(5);
    chk("R10 irq on rise", {7'b0, modem_irq}, 8'h01);
    chk("R10 second pulse", 8'(res_cnt - r0), 8'h02);
    wr(2'd0, 8'h00); wr(2'd2, 8'hFF);
    @(negedge clk); ring_n = 1'b0;
    idle(5);
    chk("R10 irq without resume", {7'b0, modem_irq}, 8'h01);
    chk("R10 no resume when disabled", 8'(res_cnt - r0), 8'h02);
    @(negedge clk); ring_n = 1'b1;
    idle(5);
    wr(2'd2, 8'hFF);

    // R9 falling polarity
    wr(2'd1, 8'h01);
    @(negedge clk); ext_smi = 1'b1;
    idle(5);
    wr(2'd2, 8'hFF);
    rd(2'd2, r); chk("R9 rise ignored", r, 8'h00);
    @(negedge clk); ext_smi = 1'b0;
    idle(5);
    rd(2'd2, r); chk("R9 falling sets", r, 8'h08);
    chk("R9 smi raised", {7'b0, smi_req}, 8'h01);
    wr(2'd2, 8'hFF);

    // R13 readback
    wr(2'd0, 8'hA5);
    rd(2'd0, r); chk("R13 ctrl", r, 8'hA5);
    wr(2'd1, 8'hFF);
    rd(2'd1, r); chk("R13 cfg", r, 8'h03);
    rd(2'd3, r); chk("R13 levels idle", r, 8'h4F);
    @(negedge clk); ac_present = 1'b1;
    idle(4);
    rd(2'd3, r); chk("R13 levels AC", r, 8'h5F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule